// File: doc/BRIEF.md
# One-Wire Bus Master

This block runs a single open-drain one-wire line on behalf of a host. The host picks one of four operations and pulses a start strobe: a bus reset with presence detection, a byte write, a byte read, or an automatic fetch of an attached device's ROM identity. The block builds each operation from fixed-length time slots measured in microseconds. The microsecond count comes from a divider on the system clock, so every slot edge lands on an exact number of clock cycles.

The line is modelled as two signals. One is a pull-low enable, which the block never uses to drive the line high. The other is the line's sampled level, which passes through two synchroniser flops before any decision is taken. While an operation runs the block reports busy. At completion it gives a one-cycle done pulse, together with the byte read, the presence result, or the 48-bit serial number and the check byte received from the device.

Top module: `ow_master`

## Requirements
- R1: A bus reset pulls the line low for exactly 480 us. It releases the line, samples it 70 us after release, and finishes 960 us after the pull began. With K clock cycles per microsecond, done appears 960*K+2 cycles after the start strobe was taken.
- R2: After a reset, present_o is 1 if the sampled level was low and 0 if it was high.
- R3: A written 1 bit pulls the line low for 6 us, and the slot lasts 70 us in total.
- R4: A written 0 bit pulls the line low for 60 us, and the slot lasts 70 us in total. A byte operation takes 8*(70*K+2)+1 cycles from strobe to done, counting the strobe cycle.
- R5: A read slot pulls low for 6 us and takes the bit from the line level 15 us after the slot began (9 us after release). The slot lasts 70 us.
- R6: Bytes travel least significant bit first in both directions. A read byte is assembled by shifting right, with each new bit entering at bit 7.
- R7: The identity fetch (op 3) performs a reset and then writes 0x33. It reads and discards one byte, then reads six identity bytes into serial_o, the first received at bits [7:0]. It then reads one check byte into crc_o, for 73 slots in total.
- R8: A start strobe that arrives while busy_o is high is ignored. The running operation keeps its timing and its results, and no further slot follows it.
- R9: done_o is high for exactly one cycle. busy_o is already low in that cycle.
- R10: drive_low_o is only ever asserted while busy_o is high, and it is low out of reset.
- R11: Operation codes on op_i are 0 for reset, 1 for write byte, 2 for read byte and 3 for identity fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| op_i | input | 2 | Operation select (R11) |
| wdata_i | input | 8 | Byte to write |
| line_i | input | 1 | Sampled bus level (asynchronous) |
| drive_low_o | output | 1 | Pull-low enable for the bus |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| present_o | output | 1 | Device answered the last reset |
| rdata_o | output | 8 | Byte from the last read |
| serial_o | output | 48 | Identity bytes from the last fetch |
| crc_o | output | 8 | Check byte from the last fetch |

## Verification
A bench device model watches the pull-low width of every slot to decode written bits, answers reads by holding the line low, and drives a presence pulse after any long pull. Writes and reads are swept over sixteen byte values spread across the whole range. Each value is checked for pulse width per bit, bit order and total cycle count, which separates a 1-slot from a 0-slot and LSB-first from MSB-first. Read holds that end shortly before and shortly after the 15 us point show whether sampling happens there rather than earlier or later. Identity fetches with and without a device show that the family byte is discarded and that the identity and check bytes land in the correct lanes.

// File: rtl/ow_pkg.sv
package ow_pkg;

    localparam int US_W      = 10;
    localparam int ID_BYTES  = 6;
    localparam int ROM_BYTES = ID_BYTES + 2;
    localparam logic [7:0] ROM_CMD = 8'h33;

    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_ROM   = 2'd3
    } ow_op_e;

    typedef enum logic [1:0] {
        SLOT_RST,
        SLOT_W0,
        SLOT_W1,
        SLOT_RD
    } slot_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LAUNCH,
        SQ_WAIT
    } seq_e;

    typedef enum logic [1:0] {
        PH_RST,
        PH_TX,
        PH_RX
    } phase_e;

    // Slot profile in microseconds; a sample time of zero means no sample.
    typedef struct packed {
        logic [US_W-1:0] low_us;
        logic [US_W-1:0] smp_us;
        logic [US_W-1:0] end_us;
    } slot_time_t;

    function automatic slot_time_t slot_timing(slot_e k);
        slot_time_t t;
        case (k)
            SLOT_RST: t = '{low_us: 10'd480, smp_us: 10'd550, end_us: 10'd960};
            SLOT_W0:  t = '{low_us: 10'd60,  smp_us: 10'd0,   end_us: 10'd70};
            SLOT_W1:  t = '{low_us: 10'd6,   smp_us: 10'd0,   end_us: 10'd70};
            default:  t = '{low_us: 10'd6,   smp_us: 10'd15,  end_us: 10'd70};
        endcase
        return t;
    endfunction

endpackage

// File: rtl/ow_tick.sv
module ow_tick #(
    parameter int CLK_PER_US = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int DW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [DW-1:0] LAST = DW'(CLK_PER_US - 1);

    logic [DW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)       cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = !clr && (cnt == LAST);

    generate
        if (CLK_PER_US > 1) begin : g_chk
            // R1: microsecond ticks are isolated single cycles
            p_tick_isolated_r1: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/ow_sync.sv
module ow_sync (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic s1;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b1;
            q  <= 1'b1;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end

endmodule

// File: rtl/ow_slot.sv
module ow_slot
    import ow_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  go,
    input  slot_e kind,
    input  logic  tick,
    input  logic  line_s,
    output logic  active,
    output logic  done,
    output logic  bit_q,
    output logic  drive_low
);
    slot_e           kind_q;
    logic [US_W-1:0] us;
    logic [US_W-1:0] us_nx;
    slot_time_t      t;

    always_comb begin
        t     = slot_timing(kind_q);
        us_nx = us + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            done   <= 1'b0;
            bit_q  <= 1'b1;
            us     <= '0;
            kind_q <= SLOT_RST;
        end else begin
            done <= 1'b0;
            if (go && !active) begin
                active <= 1'b1;
                kind_q <= kind;
                us     <= '0;
            end else if (active && tick) begin
                us <= us_nx;
                if (us_nx == t.smp_us) bit_q <= line_s;
                if (us_nx == t.end_us) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    assign drive_low = active && (us < t.low_us);

    // R1: a completed slot has just left the active state
    p_done_ends_slot_r1: assert property (@(posedge clk) disable iff (rst)
        done |-> (!active && $past(active)));

    // R5: the microsecond count never runs past the slot end
    p_us_bound_r5: assert property (@(posedge clk) disable iff (rst)
        active |-> (us < t.end_us));

endmodule

// File: rtl/ow_master.sv
module ow_master
    import ow_pkg::*;
#(
    parameter int CLK_PER_US = 250
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [1:0]  op_i,
    input  logic [7:0]  wdata_i,
    input  logic        line_i,
    output logic        drive_low_o,
    output logic        busy_o,
    output logic        done_o,
    output logic        present_o,
    output logic [7:0]  rdata_o,
    output logic [47:0] serial_o,
    output logic [7:0]  crc_o
);
    localparam int BN_W = $clog2(ROM_BYTES) + 1;

    seq_e            sq;
    phase_e          ph;
    ow_op_e          op_q;
    logic [7:0]      sh;
    logic [7:0]      rx_nx;
    logic [2:0]      bit_n;
    logic [BN_W-1:0] byte_n;

    logic  line_s, tick, slot_go, slot_active, slot_done, slot_bit;
    slot_e slot_kind;

    ow_sync u_sync (.clk(clk), .rst(rst), .d(line_i), .q(line_s));

    ow_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk(clk), .rst(rst), .clr(slot_go), .tick(tick));

    ow_slot u_slot (
        .clk(clk), .rst(rst), .go(slot_go), .kind(slot_kind), .tick(tick),
        .line_s(line_s), .active(slot_active), .done(slot_done),
        .bit_q(slot_bit), .drive_low(drive_low_o));

    always_comb begin
        slot_go = (sq == SQ_LAUNCH);
        case (ph)
            PH_RST:  slot_kind = SLOT_RST;
            PH_TX:   slot_kind = sh[0] ? SLOT_W1 : SLOT_W0;
            default: slot_kind = SLOT_RD;
        endcase
        rx_nx  = {slot_bit, sh[7:1]};
        busy_o = (sq != SQ_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sq        <= SQ_IDLE;
            ph        <= PH_RST;
            op_q      <= OP_RESET;
            sh        <= '0;
            bit_n     <= '0;
            byte_n    <= '0;
            done_o    <= 1'b0;
            present_o <= 1'b0;
            rdata_o   <= '0;
            serial_o  <= '0;
            crc_o     <= '0;
        end else begin
            done_o <= 1'b0;
            case (sq)
                SQ_IDLE: if (start_i) begin
                    op_q   <= ow_op_e'(op_i);
                    bit_n  <= '0;
                    byte_n <= '0;
                    sq     <= SQ_LAUNCH;
                    case (ow_op_e'(op_i))
                        OP_WRITE: begin ph <= PH_TX; sh <= wdata_i; end
                        OP_READ:  begin ph <= PH_RX; sh <= '0;      end
                        default:  ph <= PH_RST;
                    endcase
                end
                SQ_LAUNCH: sq <= SQ_WAIT;
                default: if (slot_done) begin
                    sq <= SQ_LAUNCH;
                    case (ph)
                        PH_RST: begin
                            present_o <= !slot_bit;
                            if (op_q == OP_RESET) begin
                                sq     <= SQ_IDLE;
                                done_o <= 1'b1;
                            end else begin
                                ph    <= PH_TX;
                                sh    <= ROM_CMD;
                                bit_n <= '0;
                            end
                        end
                        PH_TX: begin
                            sh    <= {1'b0, sh[7:1]};
                            bit_n <= bit_n + 1'b1;
                            if (bit_n == 3'd7) begin
                                if (op_q == OP_WRITE) begin
                                    sq     <= SQ_IDLE;
                                    done_o <= 1'b1;
                                end else begin
                                    ph     <= PH_RX;
                                    byte_n <= '0;
                                end
                            end
                        end
                        default: begin
                            sh    <= rx_nx;
                            bit_n <= bit_n + 1'b1;
                            if (bit_n == 3'd7) begin
                                if (op_q == OP_READ) begin
                                    rdata_o <= rx_nx;
                                    sq      <= SQ_IDLE;
                                    done_o  <= 1'b1;
                                end else begin
                                    for (int i = 0; i < ID_BYTES; i++)
                                        if (byte_n == BN_W'(i + 1))
                                            serial_o[i*8 +: 8] <= rx_nx;
                                    if (byte_n == BN_W'(ROM_BYTES - 1)) begin
                                        crc_o  <= rx_nx;
                                        sq     <= SQ_IDLE;
                                        done_o <= 1'b1;
                                    end else begin
                                        byte_n <= byte_n + 1'b1;
                                    end
                                end
                            end
                        end
                    endcase
                end
            endcase
        end
    end

    // R9: completion pulse lasts one cycle
    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9: busy is already clear when done is shown
    p_done_not_busy_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R8: a strobe during an operation leaves the latched operation alone
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> $stable(op_q));

    // R10: the line is only pulled during an operation
    p_drive_in_op_r10: assert property (@(posedge clk) disable iff (rst)
        drive_low_o |-> busy_o);

    // R10: a slot is only in flight while the sequencer is busy
    p_slot_in_op_r10: assert property (@(posedge clk) disable iff (rst)
        slot_active |-> busy_o);

endmodule

// File: tb/ow_master_bench.sv
`timescale 1ns/1ps
module ow_master_bench;
    localparam int K = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'd0;
    logic [7:0]  wdata_i = 8'h00;
    logic        line_i;
    logic        drive_low_o, busy_o, done_o, present_o;
    logic [7:0]  rdata_o, crc_o;
    logic [47:0] serial_o;

    always #2 clk = ~clk;

    ow_master #(.CLK_PER_US(K)) u_ow_master (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .wdata_i(wdata_i),
        .line_i(line_i), .drive_low_o(drive_low_o), .busy_o(busy_o),
        .done_o(done_o), .present_o(present_o), .rdata_o(rdata_o),
        .serial_o(serial_o), .crc_o(crc_o));

    // Device model controls
    logic        dev_present = 1'b0;
    logic        dev_resp = 1'b0;
    int          dev_resp_start = 0;
    int          dev_hold_us = 30;
    logic [71:0] dev_tx = '0;

    // Device model state
    logic        pull = 1'b0;
    logic        prev_drv = 1'b0;
    int          low_len = 0;
    int          slot_idx = 0;
    int          hold = 0;
    int          pres = -1;
    logic [7:0]  dev_rx = '0;
    logic [7:0]  dev_cmd = '0;
    int          mon_w [0:127];
    int          mon_n = 0;
    int          idle_drive = 0;

    assign line_i = !(drive_low_o || pull);

    always @(negedge clk) begin
        if (rst) begin
            prev_drv = 1'b0; low_len = 0; slot_idx = 0; hold = 0; pres = -1; pull = 1'b0;
        end else begin
            if (drive_low_o && !busy_o) idle_drive++;
            if (drive_low_o && !prev_drv) begin
                low_len = 0;
                if (dev_resp && slot_idx >= dev_resp_start && slot_idx - dev_resp_start < 72)
                    if (!dev_tx[slot_idx - dev_resp_start]) hold = dev_hold_us * K;
            end
            if (drive_low_o) low_len++;
            if (!drive_low_o && prev_drv) begin
                mon_w[mon_n % 128] = low_len;
                mon_n++;
                if (low_len > 400 * K) begin
                    slot_idx = 0; dev_rx = '0; pres = 0;
                end else begin
                    dev_rx = {(low_len < 15 * K), dev_rx[7:1]};
                    slot_idx++;
                    if (slot_idx == 8) dev_cmd = dev_rx;
                end
            end
            pull = (hold > 0) || (pres >= 20 * K && pres < 140 * K && dev_present);
            if (hold > 0) hold--;
            if (pres >= 0) pres = (pres > 200 * K) ? -1 : pres + 1;
            prev_drv = drive_low_o;
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Runs one operation; returns cycles from the strobe to the done pulse.
    task automatic run_op(input logic [1:0] op, input logic [7:0] d, output int n);
        @(negedge clk);
        start_i = 1'b1; op_i = op; wdata_i = d;
        n = 0;
        do begin
            @(negedge clk);
            start_i = 1'b0;
            n++;
        end while (!done_o && n < 20000);
        chk(!busy_o, "R9 busy low at done", 64'(busy_o), 64'd0);
        @(negedge clk);
        chk(!done_o, "R9 done one cycle", 64'(done_o), 64'd0);
    endtask

    initial begin
        int n;
        int base;
        logic [7:0] v;
        logic [47:0] id;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy_o && !done_o && !drive_low_o && !present_o, "R10 reset state",
            {busy_o, done_o, drive_low_o, present_o}, 64'd0);

        // R1/R2: reset without a device, then with one
        base = mon_n;
        run_op(2'd0, 8'h00, n);
        chk(n == 960 * K + 3, "R1 reset duration", n, 960 * K + 3);
        chk(mon_w[base % 128] == 480 * K, "R1 reset low width", mon_w[base % 128], 480 * K);
        chk(present_o == 1'b0, "R2 no device", present_o, 0);
        dev_present = 1'b1;
        run_op(2'd0, 8'h00, n);
        chk(present_o == 1'b1, "R2 device present", present_o, 1);

        // R3/R4/R6: write sweep
        for (int i = 0; i < 16; i++) begin
            v = 8'(i * 17);
            base = mon_n;
            run_op(2'd1, v, n);
            chk(n == 8 * (70 * K + 2) + 1, "R4 byte duration", n, 8 * (70 * K + 2) + 1);
            chk(dev_rx == v, "R6 written byte LSB first", dev_rx, v);
            for (int b = 0; b < 8; b++) begin
                if (v[b]) chk(mon_w[(base + b) % 128] == 6 * K, "R3 one-bit low width",
                              mon_w[(base + b) % 128], 6 * K);
                else      chk(mon_w[(base + b) % 128] == 60 * K, "R4 zero-bit low width",
                              mon_w[(base + b) % 128], 60 * K);
            end
        end

        // R5/R6: read sweep, each preceded by a reset
        dev_resp = 1'b1; dev_resp_start = 0;
        for (int i = 0; i < 16; i++) begin
            v = 8'(255 - i * 17);
            dev_tx = {64'd0, v};
            run_op(2'd0, 8'h00, n);
            base = mon_n;
            run_op(2'd2, 8'h00, n);
            chk(rdata_o == v, "R6 read byte LSB first", rdata_o, v);
            chk(n == 8 * (70 * K + 2) + 1, "R5 read byte duration", n, 8 * (70 * K + 2) + 1);
            chk(mon_w[base % 128] == 6 * K, "R5 read low width", mon_w[base % 128], 6 * K);
        end

        // R5: sample point lies between 12 us and 18 us
        dev_tx = '0;
        dev_hold_us = 12;
        run_op(2'd0, 8'h00, n);
        run_op(2'd2, 8'h00, n);
        chk(rdata_o == 8'hFF, "R5 early release reads one", rdata_o, 8'hFF);
        dev_hold_us = 18;
        run_op(2'd0, 8'h00, n);
        run_op(2'd2, 8'h00, n);
        chk(rdata_o == 8'h00, "R5 late release reads zero", rdata_o, 8'h00);
        dev_hold_us = 30;

        // R7: identity fetch with a device
        id = 48'h9C_3E_71_05_D2_A4;
        dev_tx = {8'h5B, id, 8'h01};
        dev_resp_start = 8;
        base = mon_n;
        run_op(2'd3, 8'h00, n);
        chk(n == 960 * K + 2 + 72 * (70 * K + 2) + 1, "R7 fetch duration", n,
            960 * K + 2 + 72 * (70 * K + 2) + 1);
        chk(mon_n - base == 73, "R7 slot count", mon_n - base, 73);
        chk(dev_cmd == 8'h33, "R7 command byte", dev_cmd, 8'h33);
        chk(serial_o == id, "R7 identity bytes", serial_o, id);
        chk(crc_o == 8'h5B, "R7 check byte", crc_o, 8'h5B);
        chk(present_o == 1'b1, "R7 presence", present_o, 1);

        // R7/R2: fetch with no device reads all ones
        dev_present = 1'b0; dev_resp = 1'b0;
        run_op(2'd3, 8'h00, n);
        chk(present_o == 1'b0, "R2 fetch no device", present_o, 0);
        chk(serial_o == 48'hFFFF_FFFF_FFFF, "R7 empty identity", serial_o, 48'hFFFF_FFFF_FFFF);
        chk(crc_o == 8'hFF, "R7 empty check byte", crc_o, 8'hFF);

        // R8/R11: strobe for a write during a reset is ignored
        base = mon_n;
        @(negedge clk);
        start_i = 1'b1; op_i = 2'd0;
        @(negedge clk);
        start_i = 1'b0;
        repeat (10) @(negedge clk);
        start_i = 1'b1; op_i = 2'd1; wdata_i = 8'h00;
        @(negedge clk);
        start_i = 1'b0;
        n = 12;
        while (!done_o && n < 20000) begin @(negedge clk); n++; end
        chk(n == 960 * K + 3, "R8 reset timing kept", n, 960 * K + 3);
        repeat (200) @(negedge clk);
        chk(!busy_o && mon_n - base == 1, "R8 no extra slot", mon_n - base, 1);

        chk(idle_drive == 0, "R10 no pull while idle", idle_drive, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule